// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer

This block decides in which operating mode a CAN controller runs: halted for configuration, running on the bus, asleep, or resynchronising to the bus after a halt or a sleep. Software drives it through writes to a mode-control register, which has three fields: halt request, sleep request and wake-on-bus enable. The block also watches the received bus bit at each bit-time strobe. It does not time bits, run the frame protocol or own mailboxes. It reports the current mode, the readable register fields, a bus-participation enable, a freeze signal for the error counters and an access permit for each register group.

Sleep is reached only from halt, through one write that clears the halt field and sets the sleep field at the same time. Sleep ends in one of two ways. Software can write the sleep field to zero. If wake-on-bus is enabled, a dominant bit on the bus also ends it. Either way, the block then waits for a run of consecutive recessive bits before it rejoins the bus. While asleep, only the mode-control, status, interrupt-request and interrupt-mask register groups stay reachable.

Top module: `can_mode_seq`

## Requirements
- R1: After a synchronous reset, `mode` is 0 (halt), `sleep_flag` and `wake_en_flag` are 0, `halt_flag` is 1, `bus_en` is 0 and every bit of `grp_ok` is 1.
- R2: In halt, a write with halt=0 and sleep=1 moves `mode` to 2 (sleep) on the next cycle and sets `sleep_flag`. Sleep is never entered from run (1) or resync (3).
- R3: The sleep field is stored only in halt or sleep mode. Written in run or resync, it leaves `sleep_flag` at 0 and causes no sleep transition. A write with halt=1 and sleep=1 in halt keeps the mode at halt with `sleep_flag`=1.
- R4: In sleep, a write with sleep=0 clears `sleep_flag` and moves `mode` to 3 (resync) if halt=0, or to 0 (halt) if halt=1. A write with sleep=1 keeps the block in sleep.
- R5: In sleep with `wake_en_flag`=1 and no write, a bit strobe with `bus_rx`=0 (dominant) moves `mode` to 3 and clears `sleep_flag` on the next cycle.
- R6: In sleep with `wake_en_flag`=0, bus activity has no effect. The mode stays 2 and the flags do not change.
- R7: Resync is also entered from halt by a write with halt=0 and sleep=0. In resync, `mode` becomes 1 (run) one cycle after the 11th consecutive recessive bit strobe. A dominant strobe restarts the count, and every entry into resync starts from zero.
- R8: `bus_en` is 1 exactly when `mode` is 1.
- R9: `cnt_hold` (error counters frozen) is 1 exactly when `mode` is 2.
- R10: In sleep, `grp_ok` is 8'h0F: group 0 = mode control, 1 = status, 2 = interrupt request, 3 = interrupt mask. In every other mode `grp_ok` is 8'hFF.
- R11: A write with halt=1 in run or resync moves `mode` to 0 on the next cycle.
- R12: In sleep, a register write and a dominant bit strobe in the same cycle resolve in favour of the write. The bus wake is discarded for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode-control register write strobe |
| wr_halt | input | 1 | Written halt-request field |
| wr_sleep | input | 1 | Written sleep-request field |
| wr_wake_en | input | 1 | Written wake-on-bus enable field |
| bit_tick | input | 1 | One-cycle strobe at each bus bit sample point |
| bus_rx | input | 1 | Received bus bit, 1 = recessive, 0 = dominant |
| mode | output | 2 | 0 halt, 1 run, 2 sleep, 3 resync |
| halt_flag | output | 1 | Readable halt field |
| sleep_flag | output | 1 | Readable sleep field |
| wake_en_flag | output | 1 | Readable wake-on-bus enable field |
| bus_en | output | 1 | Bus participation enable |
| cnt_hold | output | 1 | Freeze for the receive and transmit error counters |
| grp_ok | output | 8 | Access permit, one bit per register group |

## Verification
Two events can fall in the same cycle: a software write to the mode register and a dominant-bit strobe that would wake the block from sleep. The bench forces this by driving a write that keeps sleep set together with a dominant strobe while wake-on-bus is enabled. It then checks that the block stays asleep and that a later strobe with no write does wake it. A write that halts the block in the same cycle as the 11th recessive strobe during resync is a second collision, and the bench judges it against a behavioural model that lets the halt win.

// File: rtl/can_mode_pkg.sv
// Package: shared mode encoding and sizing for the CAN mode sequencer.
// Assumes: mode codes are visible at the top-level port and must stay fixed.
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_HALT   = 2'd0,
        MODE_RUN    = 2'd1,
        MODE_SLEEP  = 2'd2,
        MODE_RESYNC = 2'd3
    } mode_e;

    localparam int unsigned RECESSIVE_RUN_DEF = 11;
    localparam int unsigned NUM_GRP_DEF       = 8;

endpackage

// File: rtl/can_mode_ctl.sv
// Module: readable mode-control fields (sleep and wake-on-bus enable).
// Assumes: the sleep field is accepted only in halt or sleep mode, and a bus
// wake event (already qualified by the FSM) clears the sleep field.
module can_mode_ctl
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_sleep,
    input  logic  wr_wake_en,
    input  mode_e cur_mode,
    input  logic  wake_evt,
    output logic  sleep_q,
    output logic  wake_en_q
);

    logic sleep_accept;

    // Sleep field is writable only while halted or asleep.
    always_comb begin
        sleep_accept = (cur_mode == MODE_HALT) || (cur_mode == MODE_SLEEP);
    end

    // Update the sleep field on writes; a bus wake clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
        end else if (wr_en) begin
            sleep_q <= wr_sleep && sleep_accept;
        end else if (wake_evt) begin
            sleep_q <= 1'b0;
        end
    end

    // Store the wake-on-bus enable on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en_q <= 1'b0;
        end else if (wr_en) begin
            wake_en_q <= wr_wake_en;
        end
    end

    assert_wake_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !sleep_q);

endmodule

// File: rtl/can_resync_cnt.sv
// Module: counts consecutive recessive bit strobes while resynchronising.
// Assumes: enable is high only in resync mode; the count restarts on every
// entry and on any dominant strobe. done pulses on the final recessive bit.
module can_resync_cnt #(
    parameter int unsigned RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_tick,
    input  logic bus_rx,
    output logic done
);

    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt;

    // Final recessive strobe of the required run.
    always_comb begin
        done = en && bit_tick && bus_rx && (cnt == LAST);
    end

    // Count recessive strobes, restart on dominant or when not resyncing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (bit_tick) begin
            if (bus_rx) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    assert_dom_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_tick && !bus_rx) |=> (cnt == '0));

endmodule

// File: rtl/can_mode_fsm.sv
// Module: operating-mode state machine (halt, run, sleep, resync).
// Assumes: write fields are valid with wr_en; bit_tick is a one-cycle strobe.
// In sleep, a write takes precedence over a bus wake in the same cycle.
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_halt,
    input  logic  wr_sleep,
    input  logic  wake_en_q,
    input  logic  bit_tick,
    input  logic  bus_rx,
    input  logic  resync_done,
    output mode_e cur_mode,
    output logic  wake_evt
);

    mode_e nxt_mode;

    // Qualified bus wake: enabled, asleep, dominant strobe, no write.
    always_comb begin
        wake_evt = (cur_mode == MODE_SLEEP) && wake_en_q && bit_tick
                   && !bus_rx && !wr_en;
    end

    // Next-mode selection.
    always_comb begin
        nxt_mode = cur_mode;
        unique case (cur_mode)
            MODE_HALT: begin
                if (wr_en && !wr_halt) begin
                    nxt_mode = wr_sleep ? MODE_SLEEP : MODE_RESYNC;
                end
            end
            MODE_RUN: begin
                if (wr_en && wr_halt) begin
                    nxt_mode = MODE_HALT;
                end
            end
            MODE_SLEEP: begin
                if (wr_en && !wr_sleep) begin
                    nxt_mode = wr_halt ? MODE_HALT : MODE_RESYNC;
                end else if (wake_evt) begin
                    nxt_mode = MODE_RESYNC;
                end
            end
            MODE_RESYNC: begin
                if (wr_en && wr_halt) begin
                    nxt_mode = MODE_HALT;
                end else if (resync_done) begin
                    nxt_mode = MODE_RUN;
                end
            end
            default: nxt_mode = MODE_HALT;
        endcase
    end

    // Mode register; reset lands in halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= MODE_HALT;
        end else begin
            cur_mode <= nxt_mode;
        end
    end

    assert_sleep_from_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_RUN || cur_mode == MODE_RESYNC) |=> (cur_mode != MODE_SLEEP));

    assert_no_wake_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SLEEP && !wake_en_q && !wr_en) |=> (cur_mode == MODE_SLEEP));

    assert_join_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_RESYNC && !resync_done) |=> (cur_mode != MODE_RUN));

    assert_write_beats_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SLEEP && wr_en && wr_sleep) |=> (cur_mode == MODE_SLEEP));

endmodule

// File: rtl/can_access_gate.sv
// Module: per-group register access permits.
// Assumes: during sleep only the groups set in OPEN_MASK are reachable;
// all groups are reachable in every other mode.
module can_access_gate #(
    parameter int unsigned          NUM_GRP   = 8,
    parameter logic [NUM_GRP-1:0]   OPEN_MASK = 8'h0F
) (
    input  logic               asleep,
    output logic [NUM_GRP-1:0] grp_ok
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        // One permit per register group.
        always_comb begin
            grp_ok[g] = OPEN_MASK[g] || !asleep;
        end
    end

endmodule

// File: rtl/can_mode_seq.sv
// Module: top of the CAN operating-mode sequencer.
// Assumes: synchronous active-low reset; bus_rx is already synchronised and
// sampled at bit_tick. Outputs are registered state or simple decodes of it.
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int unsigned        RUN_LEN   = RECESSIVE_RUN_DEF,
    parameter int unsigned        NUM_GRP   = NUM_GRP_DEF,
    parameter logic [NUM_GRP-1:0] OPEN_MASK = 8'h0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_halt,
    input  logic               wr_sleep,
    input  logic               wr_wake_en,
    input  logic               bit_tick,
    input  logic               bus_rx,
    output logic [1:0]         mode,
    output logic               halt_flag,
    output logic               sleep_flag,
    output logic               wake_en_flag,
    output logic               bus_en,
    output logic               cnt_hold,
    output logic [NUM_GRP-1:0] grp_ok
);

    mode_e cur_mode;
    logic  wake_evt;
    logic  resync_done;
    logic  sleep_q;
    logic  wake_en_q;

    can_mode_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sleep   (wr_sleep),
        .wr_wake_en (wr_wake_en),
        .cur_mode   (cur_mode),
        .wake_evt   (wake_evt),
        .sleep_q    (sleep_q),
        .wake_en_q  (wake_en_q)
    );

    can_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_halt     (wr_halt),
        .wr_sleep    (wr_sleep),
        .wake_en_q   (wake_en_q),
        .bit_tick    (bit_tick),
        .bus_rx      (bus_rx),
        .resync_done (resync_done),
        .cur_mode    (cur_mode),
        .wake_evt    (wake_evt)
    );

    can_resync_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cur_mode == MODE_RESYNC),
        .bit_tick (bit_tick),
        .bus_rx   (bus_rx),
        .done     (resync_done)
    );

    can_access_gate #(.NUM_GRP(NUM_GRP), .OPEN_MASK(OPEN_MASK)) u_gate (
        .asleep (cur_mode == MODE_SLEEP),
        .grp_ok (grp_ok)
    );

    // Port decodes of the mode and control fields.
    always_comb begin
        mode         = cur_mode;
        halt_flag    = (cur_mode == MODE_HALT);
        sleep_flag   = sleep_q;
        wake_en_flag = wake_en_q;
        bus_en       = (cur_mode == MODE_RUN);
        cnt_hold     = (cur_mode == MODE_SLEEP);
    end

    assert_sleep_field_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SLEEP) |-> sleep_q);

    assert_gate_in_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SLEEP) |-> (grp_ok == OPEN_MASK));

    assert_gate_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_SLEEP) |-> (&grp_ok));

endmodule

// File: tb/tb_can_mode_seq.sv
// Bench: behavioural reference model compared against the design every cycle.
module tb_can_mode_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_halt = 1'b0, wr_sleep = 1'b0, wr_wake_en = 1'b0;
    logic       bit_tick = 1'b0, bus_rx = 1'b1;
    logic [1:0] mode;
    logic       halt_flag, sleep_flag, wake_en_flag, bus_en, cnt_hold;
    logic [7:0] grp_ok;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_run = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int m_mode = 0;
    bit m_sleep = 1'b0;
    bit m_wake = 1'b0;
    int m_run = 0;

    always #2 clk = ~clk;

    can_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_halt(wr_halt),
        .wr_sleep(wr_sleep), .wr_wake_en(wr_wake_en), .bit_tick(bit_tick),
        .bus_rx(bus_rx), .mode(mode), .halt_flag(halt_flag),
        .sleep_flag(sleep_flag), .wake_en_flag(wake_en_flag), .bus_en(bus_en),
        .cnt_hold(cnt_hold), .grp_ok(grp_ok)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int  nm;
        bit  wake;
        if (!rst_n) begin
            m_mode = 0; m_sleep = 0; m_wake = 0; m_run = 0;
        end else begin
            nm = m_mode;
            wake = (m_mode == 2) && m_wake && bit_tick && !bus_rx && !wr_en;
            if (m_mode == 0 && wr_en && !wr_halt) nm = wr_sleep ? 2 : 3;
            if (m_mode == 1 && wr_en && wr_halt) nm = 0;
            if (m_mode == 2) begin
                if (wr_en && !wr_sleep) nm = wr_halt ? 0 : 3;
                else if (wake) nm = 3;
            end
            if (m_mode == 3) begin
                if (wr_en && wr_halt) nm = 0;
                else if (bit_tick && bus_rx && m_run == 10) nm = 1;
                if (bit_tick) m_run = bus_rx ? m_run + 1 : 0;
            end
            if (wr_en) m_sleep = wr_sleep && (m_mode == 0 || m_mode == 2);
            else if (wake) m_sleep = 0;
            if (wr_en) m_wake = wr_wake_en;
            if (nm != 3 || m_mode != 3) m_run = 0;
            m_mode = nm;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            chk(cur_req, "mode", int'(mode), m_mode);
            chk(cur_req, "sleep_flag", int'(sleep_flag), int'(m_sleep));
            chk(cur_req, "wake_en_flag", int'(wake_en_flag), int'(m_wake));
            chk(cur_req, "halt_flag", int'(halt_flag), int'(m_mode == 0));
            chk("R8", "bus_en", int'(bus_en), int'(m_mode == 1));
            chk("R9", "cnt_hold", int'(cnt_hold), int'(m_mode == 2));
            chk("R10", "grp_ok", int'(grp_ok), (m_mode == 2) ? 8'h0F : 8'hFF);
        end
    end

    // Watchdog: counts as a failed check, still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_run) begin
            done_run = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(input bit we, input bit h, input bit s, input bit a,
                        input bit tk, input bit rx);
        @(negedge clk);
        wr_en = we; wr_halt = h; wr_sleep = s; wr_wake_en = a;
        bit_tick = tk; bus_rx = rx;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
    endtask

    task automatic bits(input int n, input bit rx);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, 1, rx);
            step(0, 0, 0, 0, 0, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(2);
        chk("R1", "reset mode", int'(mode), 0);
        chk("R1", "reset grp_ok", int'(grp_ok), 8'hFF);

        cur_req = "R3";
        step(1, 1, 1, 0, 0, 1); idle(2);
        chk("R3", "sleep held in halt", int'(sleep_flag), 1);

        cur_req = "R7";
        step(1, 0, 0, 0, 0, 1); idle(1);
        bits(5, 1); bits(1, 0); bits(10, 1); idle(1);
        chk("R7", "still resync after 10", int'(mode), 3);
        bits(1, 1); idle(1);
        chk("R7", "run after 11", int'(mode), 1);

        cur_req = "R3";
        step(1, 0, 1, 0, 0, 1); idle(2);
        chk("R3", "no sleep from run", int'(mode), 1);
        step(1, 1, 1, 0, 0, 1); idle(2);

        cur_req = "R2";
        step(1, 0, 1, 0, 0, 1); idle(2);
        chk("R2", "sleep entered", int'(mode), 2);

        cur_req = "R6";
        bits(5, 0); idle(1);
        chk("R6", "ignored bus", int'(mode), 2);

        cur_req = "R4";
        step(1, 0, 0, 0, 0, 1); idle(1);
        bits(4, 1);
        cur_req = "R11";
        step(1, 1, 0, 0, 0, 1); idle(2);
        chk("R11", "halt from resync", int'(mode), 0);

        cur_req = "R2";
        step(1, 0, 1, 1, 0, 1); idle(2);
        cur_req = "R12";
        step(1, 0, 1, 1, 1, 0); idle(2);
        chk("R12", "write beats wake", int'(mode), 2);

        cur_req = "R5";
        bits(1, 0); idle(1);
        chk("R5", "bus wake", int'(mode), 3);
        bits(10, 1); bits(1, 0); bits(11, 1); idle(2);
        chk("R5", "run after bus wake", int'(mode), 1);

        cur_req = "R11";
        step(1, 1, 0, 0, 0, 1); idle(1);
        cur_req = "R4";
        step(1, 0, 1, 0, 0, 1); idle(1);
        step(1, 1, 0, 0, 0, 1); idle(2);
        chk("R4", "sleep to halt", int'(mode), 0);

        cur_req = "R7";
        step(1, 0, 0, 0, 0, 1); idle(1);
        bits(10, 1);
        step(1, 1, 0, 0, 1, 1); idle(2);
        chk("R7", "halt beats 11th bit", int'(mode), 0);

        done_run = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule